// File: doc/BRIEF.md
# Elastic Store Event Latch

This block keeps four sticky event flags for a T1 line interface: two flags report activity of an internal excessive-zero event counter, and two report every change of the transmit and receive slip status levels coming from the elastic buffers. Each flag stays set until software reads either the latch register itself or the shared elastic-store interrupt status register. Both reads are presented to the block as one-cycle strobes.

The excessive-zero counter is held inside the block. It advances on a one-cycle strobe and wraps from its all-ones value to zero. Every advance sets the indication flag. A wrap sets the overflow flag and, because it is also an advance, the indication flag too.

A small two-state machine watches the slip levels. In state `EDG_ARM`, the first clock after reset is released, it captures the present levels as the reference and reports no change. It then moves to `EDG_TRACK`, where it remains until the next reset, and flags any difference between a level and its stored copy. The only transitions are reset to `EDG_ARM` and `EDG_ARM` to `EDG_TRACK`. The read word carries the flags in its low four bits. A pending output, the OR of those flags, goes to interrupt logic.

Top module: `ezl_event_latch`

## Requirements
- R1: Bit 3 of `status_word` (overflow flag) is set in the cycle after an increment strobe that moves the counter from 255 to 0.
- R2: Bit 2 of `status_word` (indication flag) is set in the cycle after every increment strobe, including the one that wraps. `ez_count` advances by one on each strobe.
- R3: Bit 1 of `status_word` is set in the cycle after `tx_slip_lvl` changes, whether it rises or falls.
- R4: Bit 0 of `status_word` is set in the cycle after `rx_slip_lvl` changes, whether it rises or falls.
- R5: A one-cycle pulse on `rd_latch` or on `rd_irq` clears all four flags in the next cycle.
- R6: When a set event and a clearing read fall in the same cycle, the flag for that event is set afterwards. Flags without an event in that cycle are cleared.
- R7: After reset, `status_word` is zero and `ez_count` is zero. Bits 15 to 4 of `status_word` always read zero.
- R8: The slip levels present when reset is released set no flag. Only later changes count.
- R9: `pending` is high exactly when any of bits 3 to 0 of `status_word` is high.
- R10: With no event and no read, every flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ez_inc | input | 1 | Excessive-zero counter increment strobe |
| tx_slip_lvl | input | 1 | Live transmit slip status level |
| rx_slip_lvl | input | 1 | Live receive slip status level |
| rd_latch | input | 1 | Strobe: read of this latch register |
| rd_irq | input | 1 | Strobe: read of the shared interrupt status register |
| status_word | output | 16 | Latched status read word |
| ez_count | output | 8 | Excessive-zero counter value |
| pending | output | 1 | Any flag set |

## Verification
The slip flags are tested with rising and falling changes on each level separately and with both levels changing together. This shows that both edges are detected and that the two flags stay independent. The counter is tested with single strobes and with a full run through 255 to 0, which separates the indication flag from the overflow flag. Reads are issued alone and in the same cycle as events, on each of the two read strobes. This distinguishes a plain clear from the rule that a set wins over a clear. A reset taken while a slip level is high checks that the reference level is captured, not treated as an edge.

// File: rtl/ezl_pkg.sv
package ezl_pkg;
    // Flag positions in the read word; interrupt logic decodes these
    localparam int FLAG_N   = 4;
    localparam int B_OVF    = 3;
    localparam int B_IND    = 2;
    localparam int B_TXSLIP = 1;
    localparam int B_RXSLIP = 0;

    typedef enum logic [0:0] {
        EDG_ARM   = 1'b0,
        EDG_TRACK = 1'b1
    } edg_state_t;
endpackage

// File: rtl/ezl_zero_counter.sv
module ezl_zero_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             inc_evt_o,
    output logic             wrap_evt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (inc_i)
            count_q <= count_q + 1'b1;
    end

    always_comb begin
        inc_evt_o  = inc_i;
        wrap_evt_o = inc_i && (count_q == CNT_MAX);
        count_o    = count_q;
    end

    // R2: each strobe advances the count by one
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> (count_q == $past(count_q) + 1'b1));
    // R1: a wrap lands on zero
    a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt_o |=> (count_q == '0));
endmodule

// File: rtl/ezl_level_edge.sv
module ezl_level_edge
    import ezl_pkg::*;
#(
    parameter int LVL_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_N-1:0] lvl_i,
    output logic [LVL_N-1:0] edge_o
);
    edg_state_t state_q, state_d;
    logic [LVL_N-1:0] ref_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= EDG_ARM;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDG_ARM:   state_d = EDG_TRACK;
            EDG_TRACK: state_d = EDG_TRACK;
            default:   state_d = EDG_ARM;
        endcase
    end

    // Reference copy of each level, one per lane
    for (genvar g = 0; g < LVL_N; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ref_q[g] <= 1'b0;
            else
                ref_q[g] <= lvl_i[g];
        end
    end

    // Outputs
    always_comb begin
        edge_o = '0;
        unique case (state_q)
            EDG_ARM:   edge_o = '0;
            EDG_TRACK: edge_o = lvl_i ^ ref_q;
            default:   edge_o = '0;
        endcase
    end

    // R3/R4: any change of a level after arming is reported
    a_r3_change_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EDG_TRACK && $past(state_q) == EDG_TRACK && lvl_i != $past(lvl_i))
        |-> (edge_o != '0));
    // R8: arming cycle reports nothing; machine never returns to arm
    a_r8_arm_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EDG_TRACK) |=> (state_q == EDG_TRACK));
endmodule

// File: rtl/ezl_sticky_bank.sv
module ezl_sticky_bank #(
    parameter int BIT_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BIT_N-1:0] set_i,
    input  logic             clr_i,
    output logic [BIT_N-1:0] q_o
);
    logic [BIT_N-1:0] q_r;

    for (genvar g = 0; g < BIT_N; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q_r[g] <= 1'b0;
            else if (set_i[g])
                q_r[g] <= 1'b1;   // set beats clear
            else if (clr_i)
                q_r[g] <= 1'b0;
        end
    end

    assign q_o = q_r;

    // R5: a read with no event empties the bank
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i == '0) |=> (q_o == '0));
    // R6: events are never lost to a read
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
    // R10: no event, no read, no change
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && set_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/ezl_event_latch.sv
module ezl_event_latch
    import ezl_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ez_inc,
    input  logic              tx_slip_lvl,
    input  logic              rx_slip_lvl,
    input  logic              rd_latch,
    input  logic              rd_irq,
    output logic [WORD_W-1:0] status_word,
    output logic [CNT_W-1:0]  ez_count,
    output logic              pending
);
    localparam int PAD_W = WORD_W - FLAG_N;

    logic              inc_evt, wrap_evt;
    logic [1:0]        slip_lvl, slip_edge;
    logic [FLAG_N-1:0] set_vec, flags;
    logic              clr;

    ezl_zero_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_i      (ez_inc),
        .count_o    (ez_count),
        .inc_evt_o  (inc_evt),
        .wrap_evt_o (wrap_evt)
    );

    assign slip_lvl = {tx_slip_lvl, rx_slip_lvl};

    ezl_level_edge #(.LVL_N(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (slip_lvl),
        .edge_o (slip_edge)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[B_OVF]    = wrap_evt;
        set_vec[B_IND]    = inc_evt;
        set_vec[B_TXSLIP] = slip_edge[1];
        set_vec[B_RXSLIP] = slip_edge[0];
        clr               = rd_latch | rd_irq;
    end

    ezl_sticky_bank #(.BIT_N(FLAG_N)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr),
        .q_o   (flags)
    );

    assign status_word = {{PAD_W{1'b0}}, flags};
    assign pending     = |flags;

    // R1: wrap sets overflow flag
    a_r1_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ez_inc && ez_count == {CNT_W{1'b1}}) |=> status_word[B_OVF]);
    // R2: strobe sets indication flag
    a_r2_ind_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ez_inc |=> status_word[B_IND]);
    // R3: transmit slip change sets its flag
    a_r3_tx_flag: assert property (@(posedge clk) disable iff (!rst_n)
        slip_edge[1] |=> status_word[B_TXSLIP]);
    // R4: receive slip change sets its flag
    a_r4_rx_flag: assert property (@(posedge clk) disable iff (!rst_n)
        slip_edge[0] |=> status_word[B_RXSLIP]);
    // R5: a read with no event empties the word
    a_r5_word_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_latch || rd_irq) && !ez_inc && slip_edge == 2'b00) |=> (status_word == '0));
endmodule

// File: tb/tb_ezl_event_latch.sv
module tb_ezl_event_latch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ez_inc = 1'b0;
    logic        tx_slip_lvl = 1'b0;
    logic        rx_slip_lvl = 1'b0;
    logic        rd_latch = 1'b0;
    logic        rd_irq = 1'b0;
    logic [15:0] status_word;
    logic [7:0]  ez_count;
    logic        pending;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ezl_event_latch dut (
        .clk(clk), .rst_n(rst_n), .ez_inc(ez_inc),
        .tx_slip_lvl(tx_slip_lvl), .rx_slip_lvl(rx_slip_lvl),
        .rd_latch(rd_latch), .rd_irq(rd_irq),
        .status_word(status_word), .ez_count(ez_count), .pending(pending)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic read_self();
        rd_latch = 1'b1; step(); rd_latch = 1'b0;
    endtask

    task automatic read_irq();
        rd_irq = 1'b1; step(); rd_irq = 1'b0;
    endtask

    // Reset with transmit slip high; the captured level is no event
    task automatic t_reset();
        tx_slip_lvl = 1'b1;
        rst_n = 1'b0;
        repeat (3) step();
        chk("R7 reset word", status_word, 16'h0);
        chk("R7 reset count", ez_count, 8'd0);
        chk("R9 reset pending", pending, 1'b0);
        rst_n = 1'b1;
        repeat (4) step();
        chk("R8 level at release ignored", status_word, 16'h0);
    endtask

    task automatic t_tx_edges();
        tx_slip_lvl = 1'b0; step();
        chk("R3 tx falling", status_word, 16'h0002);
        chk("R9 pending on tx", pending, 1'b1);
        read_self();
        chk("R5 self read clears", status_word, 16'h0);
        chk("R9 pending cleared", pending, 1'b0);
        tx_slip_lvl = 1'b1; step();
        chk("R3 tx rising", status_word, 16'h0002);
        read_irq();
        chk("R5 irq read clears", status_word, 16'h0);
    endtask

    task automatic t_rx_edges();
        rx_slip_lvl = 1'b1; step();
        chk("R4 rx rising", status_word, 16'h0001);
        read_irq();
        rx_slip_lvl = 1'b0; step();
        chk("R4 rx falling", status_word, 16'h0001);
        read_self();
        tx_slip_lvl = 1'b0; rx_slip_lvl = 1'b1; step();
        chk("R3 R4 both slips", status_word, 16'h0003);
        read_self();
        chk("R5 clear both", status_word, 16'h0);
    endtask

    task automatic t_increment();
        ez_inc = 1'b1; step(); ez_inc = 1'b0;
        chk("R2 indication", status_word, 16'h0004);
        chk("R2 count one", ez_count, 8'd1);
        repeat (5) step();
        chk("R10 hold", status_word, 16'h0004);
        chk("R10 count hold", ez_count, 8'd1);
        read_self();
        chk("R5 clear ind", status_word, 16'h0);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 254; i++) begin
            ez_inc = 1'b1; step();
        end
        ez_inc = 1'b0;
        chk("R2 count 255", ez_count, 8'd255);
        read_self();
        chk("R1 no overflow before wrap", status_word, 16'h0);
        ez_inc = 1'b1; step(); ez_inc = 1'b0;
        chk("R1 count wraps", ez_count, 8'd0);
        chk("R1 R2 overflow and indication", status_word, 16'h000C);
        chk("R7 upper bits zero", status_word[15:4], 12'h0);
        read_irq();
        chk("R5 clear after wrap", status_word, 16'h0);
    endtask

    task automatic t_collide();
        ez_inc = 1'b1; rd_latch = 1'b1; step();
        ez_inc = 1'b0; rd_latch = 1'b0;
        chk("R6 inc beats self read", status_word, 16'h0004);
        tx_slip_lvl = 1'b1; rd_irq = 1'b1; step();
        rd_irq = 1'b0;
        chk("R6 tx beats irq read, ind cleared", status_word, 16'h0002);
        read_self();
        chk("R5 final clear", status_word, 16'h0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_tx_edges();
                t_rx_edges();
                t_increment();
                t_wrap();
                t_collide();
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule